// File: doc/BRIEF.md
# Engine command and interrupt-cause register unit

This block sits between a simple word-wide host port and two engines: a transmit-side command engine and a receive engine. It has two host-visible 16-bit words. The status word collects interrupt causes that come from the engines and from software, and it reports the current state of each engine. The command word has one command field for each engine, a global interrupt mask and a software-interrupt request.

A legal command code written into an idle field is held in that field. The block announces it to its engine with a one-cycle strobe and keeps the code on a dedicated output until the engine returns an accept pulse. The field then clears. The host learns that a command was taken when both fields read zero. Cause bits are acknowledged by writing ones to the status word. A single level interrupt output is high while any cause is pending and the mask is clear.

Top module: `unit_ctl_regs`

## Requirements
- R1: While reset is low, and on the first cycle after it, every cause bit, the mask, both command fields, both strobes and `irq_out` are 0.
- R2: Address 0 reads the status word and address 1 reads the command word. The status word is laid out as causes in bits 15:8 (bit 9 always reads 0), command-engine state `cu_state` in bits 7:6, receive-engine state `ru_state` in bits 5:2, and 0 in bits 1:0.
- R3: A high bit of `hw_evt` sets a cause bit at the next clock edge. The mapping is `hw_evt[5]` to bit 15 (command done), [4] to 14 (frame received), [3] to 13 (command engine went inactive), [2] to 12 (receiver left ready), [1] to 11 (management cycle done) and [0] to 8 (flow-control pause).
- R4: A write to the status word clears each cause bit written as 1 within 0xFD00. Cause bits written as 0 do not change, and the state bits ignore the write.
- R5: If an event and an acknowledge reach the same cause bit in the same cycle, the bit ends up set.
- R6: A command-word write with bit 9 = 1 sets cause bit 10 (software interrupt). Bit 9 of the command word always reads 0.
- R7: Command bit 8 is the mask and is written by every command-word write. `irq_out` = mask is 0 and at least one cause bit is set.
- R8: The command-engine field is bits 7:4. Codes 1, 2, 4, 5, 6 and 7 are accepted. Codes 3 and 8–15 are dropped, and the field stays 0.
- R9: The receive-engine field is bits 2:0. Codes 1, 2, 4, 6 and 7 are accepted. Codes 3 and 5 are dropped.
- R10: While a field is nonzero, writes to that field are ignored and its code holds steady. The other field is handled independently.
- R11: An accept pulse while a field is nonzero clears that field at the same edge. An accept pulse while the field is zero has no effect.
- R12: Loading a field raises its strobe for exactly one cycle, the first cycle in which the loaded code is visible on the code output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Host access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = status word, 1 = command word |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| hw_evt | input | 6 | Engine event pulses (mapping in R3) |
| cu_state | input | 2 | Command-engine state |
| ru_state | input | 4 | Receive-engine state |
| cu_cmd_strobe | output | 1 | New command for the command engine |
| cu_cmd_code | output | 4 | Pending command-engine code |
| cu_accept | input | 1 | Command engine took its command |
| ru_cmd_strobe | output | 1 | New command for the receive engine |
| ru_cmd_code | output | 3 | Pending receive-engine code |
| ru_accept | input | 1 | Receive engine took its command |
| irq_out | output | 1 | Level interrupt |

## Verification
The properties assume that `hw_evt`, `cu_accept` and `ru_accept` are single-cycle pulses sampled on the rising edge. They also assume that at most one host access happens per cycle. The bench drives all of these one cycle at a time on falling edges and returns them to zero afterwards. The engine state inputs are held constant, so the low byte of the status word is predictable. Accept pulses are sometimes sent while a field is already zero, and the bench checks that this has no effect.

// File: rtl/unit_ctl_pkg.sv
// Package: shared constants for the engine command / interrupt-cause unit.
// Assumes a 16-bit host word; field positions are fixed by the host software.
package unit_ctl_pkg;
    localparam int WORD_W    = 16;
    localparam int CU_CODE_W = 4;
    localparam int RU_CODE_W = 3;
    localparam int EVT_W     = 6;

    typedef enum logic {
        ADDR_STATUS = 1'b0,
        ADDR_CMD    = 1'b1
    } word_sel_e;

    // Cause bits that exist and can be acknowledged.
    localparam logic [WORD_W-1:0] CAUSE_MASK = 16'hFD00;

    // Command word field positions.
    localparam int CU_LSB   = 4;
    localparam int RU_LSB   = 0;
    localparam int MASK_BIT = 8;
    localparam int SWI_BIT  = 9;
    localparam int SWI_CAUSE = 10;

    // Legal command codes, one bit per code value.
    localparam logic [(1<<CU_CODE_W)-1:0] CU_LEGAL = 16'h00F6; // 1,2,4,5,6,7
    localparam logic [(1<<RU_CODE_W)-1:0] RU_LEGAL = 8'hD6;    // 1,2,4,6,7
endpackage

// File: rtl/cause_bank.sv
// Cause register bank: holds interrupt causes, set by events, cleared by
// write-one acknowledge. Assumes set/ack are single-cycle qualified vectors.
// A set wins over an acknowledge on the same bit in the same cycle.
module cause_bank #(
    parameter int                 W    = 16,
    parameter logic [W-1:0]       MASK = 16'hFD00
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] ack_vec,
    output logic [W-1:0] cause_q
);
    logic [W-1:0] cause_d;

    // Next cause value: keep unacknowledged bits, add new events.
    always_comb begin
        cause_d = (set_vec | (cause_q & ~ack_vec)) & MASK;
    end

    // Cause storage.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end
endmodule

// File: rtl/cmd_field.sv
// One self-clearing command field. Accepts a legal nonzero code only while
// idle, pulses a strobe once when it loads, and clears on the engine accept.
// Assumes accept is a single-cycle pulse from the engine.
module cmd_field #(
    parameter int                  W     = 4,
    parameter logic [(1<<W)-1:0]   LEGAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_code,
    input  logic         accept,
    output logic [W-1:0] code_q,
    output logic         strobe_q
);
    logic busy;
    logic load;

    // Decode whether a write may load the field.
    always_comb begin
        busy = (code_q != '0);
        load = wr_en && !busy && (wr_code != '0) && LEGAL[wr_code];
    end

    // Field and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= load;
            if (busy && accept) code_q <= '0;
            else if (load)      code_q <= wr_code;
        end
    end
endmodule

// File: rtl/unit_ctl_regs.sv
// Top: host-visible status and command words for two engines.
// Assumes one host access per cycle; reads are combinational on bus_addr.
module unit_ctl_regs
    import unit_ctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic                 bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [EVT_W-1:0]     hw_evt,
    input  logic [1:0]           cu_state,
    input  logic [3:0]           ru_state,
    output logic                 cu_cmd_strobe,
    output logic [CU_CODE_W-1:0] cu_cmd_code,
    input  logic                 cu_accept,
    output logic                 ru_cmd_strobe,
    output logic [RU_CODE_W-1:0] ru_cmd_code,
    input  logic                 ru_accept
    ,
    output logic                 irq_out
);
    logic              wr_status;
    logic              wr_cmd;
    logic [WORD_W-1:0] set_vec;
    logic [WORD_W-1:0] ack_vec;
    logic [WORD_W-1:0] cause_q;
    logic              mask_q;

    // Decode host writes per word.
    always_comb begin
        wr_status = bus_sel && bus_wr && (bus_addr == ADDR_STATUS);
        wr_cmd    = bus_sel && bus_wr && (bus_addr == ADDR_CMD);
    end

    // Map engine events and the software request onto cause positions.
    always_comb begin
        set_vec            = '0;
        set_vec[15]        = hw_evt[5];
        set_vec[14]        = hw_evt[4];
        set_vec[13]        = hw_evt[3];
        set_vec[12]        = hw_evt[2];
        set_vec[11]        = hw_evt[1];
        set_vec[8]         = hw_evt[0];
        set_vec[SWI_CAUSE] = wr_cmd && bus_wdata[SWI_BIT];
        ack_vec            = wr_status ? bus_wdata : '0;
    end

    cause_bank #(.W(WORD_W), .MASK(CAUSE_MASK)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .ack_vec (ack_vec),
        .cause_q (cause_q)
    );

    cmd_field #(.W(CU_CODE_W), .LEGAL(CU_LEGAL)) u_cu_field (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_cmd),
        .wr_code  (bus_wdata[CU_LSB +: CU_CODE_W]),
        .accept   (cu_accept),
        .code_q   (cu_cmd_code),
        .strobe_q (cu_cmd_strobe)
    );

    cmd_field #(.W(RU_CODE_W), .LEGAL(RU_LEGAL)) u_ru_field (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_cmd),
        .wr_code  (bus_wdata[RU_LSB +: RU_CODE_W]),
        .accept   (ru_accept),
        .code_q   (ru_cmd_code),
        .strobe_q (ru_cmd_strobe)
    );

    // Global interrupt mask, rewritten by every command-word write.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= 1'b0;
        else if (wr_cmd) mask_q <= bus_wdata[MASK_BIT];
    end

    // Read mux for the two words.
    always_comb begin
        if (bus_addr == ADDR_STATUS)
            bus_rdata = cause_q | {8'h00, cu_state, ru_state, 2'b00};
        else
            bus_rdata = {6'b0, 1'b0, mask_q, cu_cmd_code, 1'b0, ru_cmd_code};
    end

    // Level interrupt.
    always_comb begin
        irq_out = !mask_q && (cause_q != '0);
    end
endmodule

// File: rtl/unit_ctl_checker.sv
// Checker for unit_ctl_regs: temporal properties on fields, causes, interrupt.
// Assumes event and accept inputs are single-cycle pulses.
module unit_ctl_checker
    import unit_ctl_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic                 bus_addr,
    input logic [WORD_W-1:0]    bus_wdata,
    input logic [EVT_W-1:0]     hw_evt,
    input logic                 cu_cmd_strobe,
    input logic [CU_CODE_W-1:0] cu_cmd_code,
    input logic                 cu_accept,
    input logic                 ru_cmd_strobe,
    input logic [RU_CODE_W-1:0] ru_cmd_code,
    input logic                 ru_accept,
    input logic                 irq_out,
    input logic [WORD_W-1:0]    cause_q
);
    a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hw_evt[4] |=> cause_q[14]);

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_addr && bus_wdata[14] && !hw_evt[4]) |=> !cause_q[14]);

    a_r5_event_beats_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_addr && bus_wdata[15] && hw_evt[5]) |=> cause_q[15]);

    a_r7_mask_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr && bus_wdata[8]) |=> !irq_out);

    a_r8_cu_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cu_cmd_strobe |-> CU_LEGAL[cu_cmd_code]);

    a_r9_ru_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ru_cmd_strobe |-> RU_LEGAL[ru_cmd_code]);

    a_r10_cu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cu_cmd_code != '0 && !cu_accept) |=> $stable(cu_cmd_code));

    a_r10_ru_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_cmd_code != '0 && !ru_accept) |=> $stable(ru_cmd_code));

    a_r11_cu_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cu_cmd_code != '0 && cu_accept) |=> (cu_cmd_code == '0));

    a_r11_ru_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ru_cmd_code != '0 && ru_accept) |=> (ru_cmd_code == '0));

    a_r12_cu_single: assert property (@(posedge clk) disable iff (!rst_n)
        cu_cmd_strobe |=> !cu_cmd_strobe);

    a_r12_ru_single: assert property (@(posedge clk) disable iff (!rst_n)
        ru_cmd_strobe |=> !ru_cmd_strobe);
endmodule

bind unit_ctl_regs unit_ctl_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .hw_evt        (hw_evt),
    .cu_cmd_strobe (cu_cmd_strobe),
    .cu_cmd_code   (cu_cmd_code),
    .cu_accept     (cu_accept),
    .ru_cmd_strobe (ru_cmd_strobe),
    .ru_cmd_code   (ru_cmd_code),
    .ru_accept     (ru_accept),
    .irq_out       (irq_out),
    .cause_q       (cause_q)
);

// File: tb/sim_unit_ctl_regs.sv
module sim_unit_ctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [5:0]  hw_evt = '0;
    logic [1:0]  cu_state = 2'd2;
    logic [3:0]  ru_state = 4'd4;
    logic        cu_cmd_strobe;
    logic [3:0]  cu_cmd_code;
    logic        cu_accept = 1'b0;
    logic        ru_cmd_strobe;
    logic [2:0]  ru_cmd_code;
    logic        ru_accept = 1'b0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    unit_ctl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .hw_evt(hw_evt), .cu_state(cu_state), .ru_state(ru_state),
        .cu_cmd_strobe(cu_cmd_strobe), .cu_cmd_code(cu_cmd_code), .cu_accept(cu_accept),
        .ru_cmd_strobe(ru_cmd_strobe), .ru_cmd_code(ru_cmd_code), .ru_accept(ru_accept),
        .irq_out(irq_out)
    );

    // Row: wr, addr, wdata, evt, cu_acc, ru_acc, chk_addr, exp_rdata, exp_irq, req
    localparam int NROW = 21;
    localparam logic [47:0] TBL [0:NROW-1] = '{
        {1'b0,1'b0,16'h0000,6'h00,1'b0,1'b0,1'b0,16'h0090,1'b0,4'd2},  // R2 idle layout
        {1'b0,1'b0,16'h0000,6'h10,1'b0,1'b0,1'b0,16'h4090,1'b1,4'd3},  // R3 frame
        {1'b1,1'b0,16'h4000,6'h00,1'b0,1'b0,1'b0,16'h0090,1'b0,4'd4},  // R4 ack
        {1'b0,1'b0,16'h0000,6'h23,1'b0,1'b0,1'b0,16'h8990,1'b1,4'd3},  // R3 three events
        {1'b1,1'b0,16'h0800,6'h00,1'b0,1'b0,1'b0,16'h8190,1'b1,4'd4},  // R4 partial ack
        {1'b1,1'b0,16'h00FF,6'h00,1'b0,1'b0,1'b0,16'h8190,1'b1,4'd4},  // R4 low byte ignored
        {1'b1,1'b0,16'h4000,6'h10,1'b0,1'b0,1'b0,16'hC190,1'b1,4'd5},  // R5 event wins
        {1'b1,1'b1,16'h0100,6'h00,1'b0,1'b0,1'b1,16'h0100,1'b0,4'd7},  // R7 mask set
        {1'b1,1'b0,16'hFD00,6'h00,1'b0,1'b0,1'b0,16'h0090,1'b0,4'd4},  // R4 ack all
        {1'b1,1'b1,16'h0300,6'h00,1'b0,1'b0,1'b0,16'h0490,1'b0,4'd6},  // R6 swi masked
        {1'b1,1'b1,16'h0000,6'h00,1'b0,1'b0,1'b1,16'h0000,1'b1,4'd7},  // R7 unmask
        {1'b1,1'b0,16'h0400,6'h00,1'b0,1'b0,1'b0,16'h0090,1'b0,4'd6},  // R6 ack swi
        {1'b1,1'b1,16'h0010,6'h00,1'b0,1'b0,1'b1,16'h0010,1'b0,4'd8},  // R8 cu start
        {1'b1,1'b1,16'h0021,6'h00,1'b0,1'b0,1'b1,16'h0011,1'b0,4'd10}, // R10 busy cu, ru loads
        {1'b0,1'b0,16'h0000,6'h00,1'b1,1'b0,1'b1,16'h0001,1'b0,4'd11}, // R11 cu accept
        {1'b0,1'b0,16'h0000,6'h00,1'b0,1'b1,1'b1,16'h0000,1'b0,4'd11}, // R11 ru accept
        {1'b0,1'b0,16'h0000,6'h00,1'b0,1'b1,1'b1,16'h0000,1'b0,4'd11}, // R11 idle accept
        {1'b1,1'b1,16'h0030,6'h00,1'b0,1'b0,1'b1,16'h0000,1'b0,4'd8},  // R8 code 3 dropped
        {1'b1,1'b1,16'h0005,6'h00,1'b0,1'b0,1'b1,16'h0000,1'b0,4'd9},  // R9 code 5 dropped
        {1'b1,1'b1,16'h0077,6'h00,1'b0,1'b0,1'b1,16'h0077,1'b0,4'd9},  // R9 both load
        {1'b0,1'b0,16'h0000,6'h00,1'b1,1'b1,1'b1,16'h0000,1'b0,4'd11}  // R11 both accept
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    task automatic idle_inputs();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        hw_evt = '0; cu_accept = 1'b0; ru_accept = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state, during and just after reset
        repeat (3) @(negedge clk);
        bus_addr = 1'b1; #1;
        check("R1", {16'h0, bus_rdata}, 32'h0);
        check("R1", {29'h0, irq_out, cu_cmd_strobe, ru_cmd_strobe}, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); bus_addr = 1'b0; #1;
        check("R1", {16'h0, bus_rdata}, 32'h0090);

        // Table walk
        for (int i = 0; i < NROW; i++) begin
            @(negedge clk);
            bus_sel   = TBL[i][47];
            bus_wr    = TBL[i][47];
            bus_addr  = TBL[i][46];
            bus_wdata = TBL[i][45:30];
            hw_evt    = TBL[i][29:24];
            cu_accept = TBL[i][23];
            ru_accept = TBL[i][22];
            @(negedge clk);
            idle_inputs();
            bus_addr = TBL[i][21]; #1;
            check($sformatf("R%0d row%0d", TBL[i][3:0], i), {16'h0, bus_rdata}, {16'h0, TBL[i][20:5]});
            check($sformatf("R%0d row%0d irq", TBL[i][3:0], i), {31'h0, irq_out}, {31'h0, TBL[i][4]});
        end

        // R12: strobe lasts one cycle, code held while pending (R10)
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 16'h0046;
        @(negedge clk); idle_inputs(); #1;
        check("R12 cu strobe", {31'h0, cu_cmd_strobe}, 32'h1);
        check("R12 ru strobe", {31'h0, ru_cmd_strobe}, 32'h1);
        check("R12 codes", {25'h0, cu_cmd_code, ru_cmd_code}, {25'h0, 4'h4, 3'h6});
        @(negedge clk); #1;
        check("R12 strobes drop", {30'h0, cu_cmd_strobe, ru_cmd_strobe}, 32'h0);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 16'h0071;
        @(negedge clk); idle_inputs(); #1;
        check("R10 held", {25'h0, cu_cmd_code, ru_cmd_code}, {25'h0, 4'h4, 3'h6});
        check("R10 no strobe", {30'h0, cu_cmd_strobe, ru_cmd_strobe}, 32'h0);
        cu_accept = 1'b1;
        @(negedge clk); idle_inputs(); #1;
        check("R11 cu only", {25'h0, cu_cmd_code, ru_cmd_code}, {25'h0, 4'h0, 3'h6});

        // R1: mid-run reset clears a pending field and causes
        hw_evt = 6'h01;
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 field", {29'h0, ru_cmd_code}, 32'h0);
        bus_addr = 1'b0; #1;
        check("R1 causes", {16'h0, bus_rdata}, 32'h0090);
        check("R1 irq", {31'h0, irq_out}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule